// File: doc/BRIEF.md
# Contactless Type B Frame Serializer

This block turns a frame of octets into the line-level chip stream of an ISO 14443 Type B link. A frame begins when `frame_start` is pulsed while the block is idle. The block then emits a synchronisation preamble and a start-of-frame pattern. Next it serializes each octet with start, stop and guard framing. It ends the frame with an end-of-frame pattern and trailing ones. One chip leaves the block for each cycle in which `chip_en` is high. The octets must already carry their CRC.

Two framings come from the same sequencer. The tag-response format stretches every logical bit over four identical chips and opens with a long run of ones that lets the far end lock its phase. The reader-command format sends one chip per bit. It puts two guard ones in front of every character and closes with an idle tail, so that the last character is out before the link turns around. The format is sampled when the frame starts.

Octets arrive through a valid/ready handshake into a single holding slot. The next octet can therefore be accepted while the current one is still on the line.

Top module: `typeb_frame_enc`

## Requirements
- R1: Out of reset, and whenever no frame is active, `ser_out` is 1 and both `busy` and `byte_ready` are 0.
- R2: In tag format, the frame opens with 80 one chips. These are followed by 40 zero chips and then 8 one chips.
- R3: In tag format, each octet is sent as one 0 bit, then its 8 data bits least significant first, then one 1 bit. Each of these bits lasts 4 identical chips, so one octet takes 40 chips.
- R4: In tag format, the frame closes with 40 zero chips followed by 40 one chips. `busy` falls at the clock edge that emits the last of these chips.
- R5: In reader format, the frame opens with 40 one chips followed by 10 zero chips.
- R6: In reader format, each octet is sent as two 1 chips, one 0 chip, then its 8 data bits least significant first. Each bit takes one chip, so one octet takes 11 chips.
- R7: In reader format, the frame closes with one 1 chip, then 10 zero chips, then 32 one chips.
- R8: `byte_ready` is 0 during preamble, start-of-frame and end-of-frame. It is also 0 from the acceptance of an octet flagged `byte_last` until the next frame. It is 1 during the character phase whenever the holding slot is empty. Every octet offered in the frame is accepted.
- R9: If no octet is held when a character slot is due, each `chip_en` emits a 1 chip until an octet arrives. The stream then resumes unchanged.
- R10: `fmt_reader` (1 = reader format, 0 = tag format) is sampled only at frame start. A change during a frame does not alter that frame.
- R11: A `frame_start` pulse during an active frame is ignored and does not disturb the stream.
- R12: A chip is emitted on `ser_out` one cycle after a rising edge at which `chip_en` is 1. The output holds its value in cycles without `chip_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Advance by one chip |
| fmt_reader | input | 1 | Format select, 1 = reader command, 0 = tag response |
| frame_start | input | 1 | Begin a frame (acted on only when idle) |
| byte_valid | input | 1 | Octet offered |
| byte_data | input | 8 | Octet value |
| byte_last | input | 1 | Offered octet is the final one of the frame |
| byte_ready | output | 1 | Holding slot can take an octet |
| ser_out | output | 1 | Serial chip stream |
| busy | output | 1 | Frame in progress |

## Verification
Each chip is registered, so it appears on `ser_out` one cycle after the `chip_en` edge that produces it. `byte_ready` changes one cycle after the phase change that opens or closes the character window. An offered octet is taken at the first rising edge where `byte_ready` is high. The bench drives `chip_en` one cycle in four and records `ser_out` at the falling edge after each enabled edge, but only while `busy` was set before that edge. It then compares the recorded stream position by position against a stream built from the requirements. For the underrun case, the run of gap chips is measured, checked to be all ones, and skipped before the rest of the stream is aligned.

// File: rtl/typeb_enc_pkg.sv
package typeb_enc_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,
        PH_SOF_LO,
        PH_SOF_HI,
        PH_GAP,
        PH_CHAR,
        PH_EOF_MARK,
        PH_EOF_LO,
        PH_EOF_HI
    } phase_e;

    // Line level of the fixed-pattern phases: only the two low runs drive 0.
    function automatic logic phase_level(phase_e p);
        return !(p == PH_SOF_LO || p == PH_EOF_LO);
    endfunction

endpackage

// File: rtl/typeb_phase_len.sv
module typeb_phase_len
    import typeb_enc_pkg::*;
#(
    parameter int TAG_REP            = 4,
    parameter int TAG_PRE_BITS       = 20,
    parameter int TAG_SOF_ZERO_BITS  = 10,
    parameter int TAG_SOF_ONE_BITS   = 2,
    parameter int TAG_EOF_ZERO_BITS  = 10,
    parameter int TAG_EOF_ONE_BITS   = 10,
    parameter int RDR_PRE_CHIPS      = 40,
    parameter int RDR_SOF_CHIPS      = 10,
    parameter int RDR_EOF_ZERO_CHIPS = 10,
    parameter int RDR_EOF_ONE_CHIPS  = 32,
    parameter int CNT_W              = 8
) (
    input  phase_e             phase,
    input  logic               rdr,
    output logic [CNT_W-1:0]   len
);

    // Chip counts of every fixed-pattern phase, per format.
    localparam logic [CNT_W-1:0] T_PRE  = CNT_W'(TAG_REP * TAG_PRE_BITS);
    localparam logic [CNT_W-1:0] T_SOFL = CNT_W'(TAG_REP * TAG_SOF_ZERO_BITS);
    localparam logic [CNT_W-1:0] T_SOFH = CNT_W'(TAG_REP * TAG_SOF_ONE_BITS);
    localparam logic [CNT_W-1:0] T_EOFL = CNT_W'(TAG_REP * TAG_EOF_ZERO_BITS);
    localparam logic [CNT_W-1:0] T_EOFH = CNT_W'(TAG_REP * TAG_EOF_ONE_BITS);
    localparam logic [CNT_W-1:0] R_PRE  = CNT_W'(RDR_PRE_CHIPS);
    localparam logic [CNT_W-1:0] R_SOF  = CNT_W'(RDR_SOF_CHIPS);
    localparam logic [CNT_W-1:0] R_EOFL = CNT_W'(RDR_EOF_ZERO_CHIPS);
    localparam logic [CNT_W-1:0] R_EOFH = CNT_W'(RDR_EOF_ONE_CHIPS);

    always_comb begin
        unique case (phase)
            PH_PRE:      len = rdr ? R_PRE  : T_PRE;
            PH_SOF_LO:   len = rdr ? R_SOF  : T_SOFL;
            PH_SOF_HI:   len = T_SOFH;
            PH_EOF_MARK: len = CNT_W'(1);
            PH_EOF_LO:   len = rdr ? R_EOFL : T_EOFL;
            PH_EOF_HI:   len = rdr ? R_EOFH : T_EOFH;
            default:     len = CNT_W'(1);
        endcase
    end

endmodule

// File: rtl/typeb_char_shaper.sv
module typeb_char_shaper #(
    parameter int TAG_REP         = 4,
    parameter int RDR_GUARD_CHIPS = 2,
    parameter int CHAR_W          = 11,
    parameter int BIT_W           = 4,
    parameter int REP_W           = 2
) (
    input  logic [7:0]        data,
    input  logic              rdr,
    output logic [CHAR_W-1:0] vec,
    output logic [BIT_W-1:0]  last_bit,
    output logic [REP_W-1:0]  rep_max
);

    localparam int SB = RDR_GUARD_CHIPS;   // position of the reader start bit

    // Character vector, bit 0 leaves first.
    always_comb begin
        vec = '1;
        if (rdr) begin
            vec[SB]          = 1'b0;
            vec[SB+8:SB+1]   = data;
            last_bit         = BIT_W'(SB + 8);
            rep_max          = '0;
        end else begin
            vec[0]           = 1'b0;
            vec[8:1]         = data;
            vec[9]           = 1'b1;
            last_bit         = BIT_W'(9);
            rep_max          = REP_W'(TAG_REP - 1);
        end
    end

endmodule

// File: rtl/typeb_byte_hold.sv
module typeb_byte_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       open,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       pop,
    output logic       full,
    output logic [7:0] out_data,
    output logic       out_last
);

    typedef struct packed {
        logic       full;
        logic       closed;
        logic [7:0] data;
        logic       last;
    } hold_t;

    hold_t hold_q, hold_d;

    assign in_ready = open && !hold_q.full && !hold_q.closed;
    assign full     = hold_q.full;
    assign out_data = hold_q.data;
    assign out_last = hold_q.last;

    always_comb begin
        hold_d = hold_q;
        if (clear) begin
            hold_d.full   = 1'b0;
            hold_d.closed = 1'b0;
        end else begin
            if (pop) begin
                hold_d.full = 1'b0;
            end
            if (in_valid && in_ready) begin
                hold_d.full = 1'b1;
                hold_d.data = in_data;
                hold_d.last = in_last;
                if (in_last) begin
                    hold_d.closed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // R9: the sequencer only takes an octet that is really held.
    p_pop_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> hold_q.full);

    // R8: once the final octet is in, no more are accepted this frame.
    p_closed_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q.closed |-> !in_ready);

endmodule

// File: rtl/typeb_frame_enc.sv
module typeb_frame_enc
    import typeb_enc_pkg::*;
#(
    parameter int TAG_REP            = 4,
    parameter int TAG_PRE_BITS       = 20,
    parameter int TAG_SOF_ZERO_BITS  = 10,
    parameter int TAG_SOF_ONE_BITS   = 2,
    parameter int TAG_EOF_ZERO_BITS  = 10,
    parameter int TAG_EOF_ONE_BITS   = 10,
    parameter int RDR_PRE_CHIPS      = 40,
    parameter int RDR_SOF_CHIPS      = 10,
    parameter int RDR_GUARD_CHIPS    = 2,
    parameter int RDR_EOF_ZERO_CHIPS = 10,
    parameter int RDR_EOF_ONE_CHIPS  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       fmt_reader,
    input  logic       frame_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       byte_last,
    output logic       byte_ready,
    output logic       ser_out,
    output logic       busy
);

    localparam int CHAR_W = 9 + ((RDR_GUARD_CHIPS > 1) ? RDR_GUARD_CHIPS : 1);
    localparam int BIT_W  = $clog2(CHAR_W + 1);
    localparam int REP_W  = (TAG_REP > 1) ? $clog2(TAG_REP) : 1;
    localparam int CNT_W  = $clog2(TAG_REP * (TAG_PRE_BITS + TAG_SOF_ZERO_BITS
                            + TAG_EOF_ZERO_BITS + TAG_EOF_ONE_BITS)
                            + RDR_PRE_CHIPS + RDR_EOF_ONE_CHIPS + 2);

    typedef struct packed {
        phase_e              ph;
        logic                rdr;
        logic [CNT_W-1:0]    cnt;
        logic [BIT_W-1:0]    bit_i;
        logic [REP_W-1:0]    rep;
        logic [CHAR_W-1:0]   sh;
        logic                last;
        logic                out;
        logic                busy;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_IDLE, rdr: 1'b0, cnt: '0, bit_i: '0,
                                 rep: '0, sh: '0, last: 1'b0, out: 1'b1,
                                 busy: 1'b0};

    seq_t seq_q, seq_d;

    logic              hold_full;
    logic [7:0]        hold_data;
    logic              hold_last;
    logic              pop;
    logic [CNT_W-1:0]  seg_len;
    logic [CHAR_W-1:0] shaped;
    logic [BIT_W-1:0]  last_bit;
    logic [REP_W-1:0]  rep_max;
    phase_e            next_fixed;

    typeb_byte_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (seq_q.ph == PH_IDLE && frame_start),
        .open     (seq_q.ph == PH_GAP || seq_q.ph == PH_CHAR),
        .in_valid (byte_valid),
        .in_data  (byte_data),
        .in_last  (byte_last),
        .in_ready (byte_ready),
        .pop      (pop),
        .full     (hold_full),
        .out_data (hold_data),
        .out_last (hold_last)
    );

    typeb_phase_len #(
        .TAG_REP            (TAG_REP),
        .TAG_PRE_BITS       (TAG_PRE_BITS),
        .TAG_SOF_ZERO_BITS  (TAG_SOF_ZERO_BITS),
        .TAG_SOF_ONE_BITS   (TAG_SOF_ONE_BITS),
        .TAG_EOF_ZERO_BITS  (TAG_EOF_ZERO_BITS),
        .TAG_EOF_ONE_BITS   (TAG_EOF_ONE_BITS),
        .RDR_PRE_CHIPS      (RDR_PRE_CHIPS),
        .RDR_SOF_CHIPS      (RDR_SOF_CHIPS),
        .RDR_EOF_ZERO_CHIPS (RDR_EOF_ZERO_CHIPS),
        .RDR_EOF_ONE_CHIPS  (RDR_EOF_ONE_CHIPS),
        .CNT_W              (CNT_W)
    ) u_len (
        .phase (seq_q.ph),
        .rdr   (seq_q.rdr),
        .len   (seg_len)
    );

    typeb_char_shaper #(
        .TAG_REP         (TAG_REP),
        .RDR_GUARD_CHIPS (RDR_GUARD_CHIPS),
        .CHAR_W          (CHAR_W),
        .BIT_W           (BIT_W),
        .REP_W           (REP_W)
    ) u_shape (
        .data     (hold_data),
        .rdr      (seq_q.rdr),
        .vec      (shaped),
        .last_bit (last_bit),
        .rep_max  (rep_max)
    );

    // Successor of each fixed-pattern phase; zero-length phases are skipped.
    always_comb begin
        unique case (seq_q.ph)
            PH_PRE:      next_fixed = PH_SOF_LO;
            PH_SOF_LO:   next_fixed = seq_q.rdr ? PH_GAP : PH_SOF_HI;
            PH_SOF_HI:   next_fixed = PH_GAP;
            PH_EOF_MARK: next_fixed = PH_EOF_LO;
            PH_EOF_LO:   next_fixed = PH_EOF_HI;
            default:     next_fixed = PH_IDLE;
        endcase
    end

    always_comb begin
        seq_d = seq_q;
        pop   = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (frame_start) begin
                    seq_d.ph   = PH_PRE;
                    seq_d.rdr  = fmt_reader;
                    seq_d.cnt  = '0;
                    seq_d.busy = 1'b1;
                end
            end
            PH_GAP: begin
                if (chip_en) begin
                    seq_d.out = 1'b1;
                end
                if (hold_full) begin
                    seq_d.sh    = shaped;
                    seq_d.last  = hold_last;
                    seq_d.bit_i = '0;
                    seq_d.rep   = '0;
                    seq_d.ph    = PH_CHAR;
                    pop         = 1'b1;
                end
            end
            PH_CHAR: begin
                if (chip_en) begin
                    seq_d.out = seq_q.sh[seq_q.bit_i];
                    if (seq_q.rep != rep_max) begin
                        seq_d.rep = seq_q.rep + 1'b1;
                    end else begin
                        seq_d.rep = '0;
                        if (seq_q.bit_i != last_bit) begin
                            seq_d.bit_i = seq_q.bit_i + 1'b1;
                        end else begin
                            seq_d.bit_i = '0;
                            if (seq_q.last) begin
                                seq_d.ph  = seq_q.rdr ? PH_EOF_MARK : PH_EOF_LO;
                                seq_d.cnt = '0;
                            end else if (hold_full) begin
                                seq_d.sh   = shaped;
                                seq_d.last = hold_last;
                                pop        = 1'b1;
                            end else begin
                                seq_d.ph = PH_GAP;
                            end
                        end
                    end
                end
            end
            default: begin
                if (chip_en) begin
                    seq_d.out = phase_level(seq_q.ph);
                    if (seq_q.cnt != seg_len - 1'b1) begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end else begin
                        seq_d.cnt = '0;
                        seq_d.ph  = next_fixed;
                        if (seq_q.ph == PH_EOF_HI) begin
                            seq_d.busy = 1'b0;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ser_out = seq_q.out;
    assign busy    = seq_q.busy;

    // R1: an inactive line rests high.
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);

    // R12: the line moves only on an enabled edge.
    p_hold_without_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> $stable(ser_out));

    // R8: the holding slot is open only in the character window.
    p_ready_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (seq_q.ph == PH_GAP || seq_q.ph == PH_CHAR));

    // R10: the format latched at start stays put for the whole frame.
    p_format_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(seq_q.rdr));

    // R11: a frame only begins from a start strobe.
    p_start_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_start));

    // R9: an underrun chip is a one.
    p_gap_chip_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_GAP && chip_en) |=> ser_out);

endmodule

// File: tb/typeb_frame_enc_tb.sv
module typeb_frame_enc_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       chip_en;
    logic       fmt_reader;
    logic       frame_start;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_last;
    logic       byte_ready;
    logic       ser_out;
    logic       busy;

    always #5 clk = ~clk;

    typeb_frame_enc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_en     (chip_en),
        .fmt_reader  (fmt_reader),
        .frame_start (frame_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_last   (byte_last),
        .byte_ready  (byte_ready),
        .ser_out     (ser_out),
        .busy        (busy)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    logic cap [0:1023];
    logic exp_bits [0:1023];
    int   cap_n, exp_len, pre_end, sof_end, chars_end, char_len;
    logic [7:0] fb [0:3];
    int   feed_n, feed_idx, gate;
    logic en_prev, busy_prev, rdy_prev, last_out;
    int   en_ctr;
    bit   ready_bad, hold_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // One clock: sample at the falling edge, then drive the next inputs.
    task automatic step();
        @(negedge clk);
        if (en_prev && busy_prev) begin
            cap[cap_n] = ser_out;
            cap_n++;
        end
        if (busy_prev && !en_prev && ser_out !== last_out) hold_bad = 1;
        last_out = ser_out;
        if (byte_valid && rdy_prev) feed_idx++;
        if (feed_idx < feed_n && (feed_idx == 0 || cap_n >= gate)) begin
            byte_valid = 1'b1;
            byte_data  = fb[feed_idx];
            byte_last  = (feed_idx == feed_n - 1);
        end else begin
            byte_valid = 1'b0;
        end
        if (byte_ready && (cap_n < sof_end || feed_idx >= feed_n)) ready_bad = 1;
        rdy_prev  = byte_ready;
        busy_prev = busy;
        en_ctr    = (en_ctr + 1) % 4;
        chip_en   = (en_ctr == 0);
        en_prev   = chip_en;
    endtask

    task automatic put(input logic v, input int k);
        for (int i = 0; i < k; i++) begin
            exp_bits[exp_len] = v;
            exp_len++;
        end
    endtask

    task automatic build(input logic rdr, input int n);
        exp_len = 0;
        if (!rdr) begin
            put(1'b1, 80); pre_end = exp_len;
            put(1'b0, 40); put(1'b1, 8); sof_end = exp_len;
            for (int b = 0; b < n; b++) begin
                put(1'b0, 4);
                for (int j = 0; j < 8; j++) put(fb[b][j], 4);
                put(1'b1, 4);
            end
            char_len = 40; chars_end = exp_len;
            put(1'b0, 40); put(1'b1, 40);
        end else begin
            put(1'b1, 40); pre_end = exp_len;
            put(1'b0, 10); sof_end = exp_len;
            for (int b = 0; b < n; b++) begin
                put(1'b1, 2); put(1'b0, 1);
                for (int j = 0; j < 8; j++) put(fb[b][j], 1);
            end
            char_len = 11; chars_end = exp_len;
            put(1'b1, 1); put(1'b0, 10); put(1'b1, 32);
        end
    endtask

    task automatic cmp_seg(input int lo, input int hi, input int gap_at,
                           input int g, input string req, input string what);
        int bad_at = -1;
        int a = 0;
        int e = 0;
        for (int i = lo; i < hi; i++) begin
            int idx = i + ((i >= gap_at) ? g : 0);
            if (idx >= cap_n || cap[idx] !== exp_bits[i]) begin
                bad_at = i;
                a = (idx >= cap_n) ? -1 : int'(cap[idx]);
                e = int'(exp_bits[i]);
                break;
            end
        end
        if (bad_at >= 0) $display("  first mismatch at expected chip %0d", bad_at);
        chk(bad_at < 0, req, what, a, e);
    endtask

    task automatic run_frame(input logic rdr, input int n, input int gate_at,
                             input int flip_at, input int restart_at,
                             input string r_pre, input string r_sof,
                             input string r_chr, input string r_eof);
        int  steps = 0;
        bit  pulsed = 0;
        int  g, gap_at;
        bit  ones;
        build(rdr, n);
        cap_n = 0; feed_idx = 0; feed_n = n; gate = gate_at;
        ready_bad = 0; hold_bad = 0;
        fmt_reader  = rdr;
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
        while (busy && steps < 30000) begin
            if (flip_at >= 0 && cap_n >= flip_at) fmt_reader = ~rdr;
            if (restart_at >= 0 && cap_n >= restart_at && !pulsed) begin
                frame_start = 1'b1;
                pulsed = 1;
            end else begin
                frame_start = 1'b0;
            end
            step();
            steps++;
        end
        frame_start = 1'b0;
        step();
        g = cap_n - exp_len;
        gap_at = (gate_at > 0) ? sof_end + char_len : exp_len;
        if (gate_at > 0) begin
            ones = 1;
            for (int i = 0; i < g; i++) if (cap[gap_at + i] !== 1'b1) ones = 0;
            chk(g > 0, "R9", "underrun gap chips", g, 1);
            chk(ones, "R9", "gap chips all one", int'(ones), 1);
        end else begin
            chk(cap_n == exp_len, r_eof, "frame chip count", cap_n, exp_len);
        end
        cmp_seg(0, pre_end, gap_at, g, r_pre, "preamble");
        cmp_seg(pre_end, sof_end, gap_at, g, r_sof, "start of frame");
        cmp_seg(sof_end, chars_end, gap_at, g, r_chr, "characters");
        cmp_seg(chars_end, exp_len, gap_at, g, r_eof, "end of frame");
        chk(!ready_bad, "R8", "ready outside character window", int'(ready_bad), 0);
        chk(feed_idx == n, "R8", "octets accepted", feed_idx, n);
        chk(!hold_bad, "R12", "output moved without chip_en", int'(hold_bad), 0);
        chk(ser_out === 1'b1 && busy === 1'b0 && byte_ready === 1'b0, "R1",
            "idle after frame", int'({ser_out, busy, byte_ready}), 4);
    endtask

    task automatic test_reset();
        chk(ser_out === 1'b1, "R1", "ser_out after reset", int'(ser_out), 1);
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(byte_ready === 1'b0, "R1", "byte_ready after reset", int'(byte_ready), 0);
    endtask

    task automatic test_tag_frame();
        fb[0] = 8'h5A; fb[1] = 8'h81;
        run_frame(1'b0, 2, 0, -1, -1, "R2", "R2", "R3", "R4");
    endtask

    task automatic test_reader_frame();
        fb[0] = 8'h05; fb[1] = 8'h00; fb[2] = 8'h08;
        run_frame(1'b1, 3, 0, -1, -1, "R5", "R5", "R6", "R7");
    endtask

    task automatic test_tag_underrun();
        fb[0] = 8'h3C; fb[1] = 8'hC3;
        run_frame(1'b0, 2, 200, -1, -1, "R2", "R2", "R3 R9", "R4 R9");
    endtask

    task automatic test_format_and_restart();
        fb[0] = 8'hFF; fb[1] = 8'h00;
        run_frame(1'b1, 2, 0, 20, 30, "R10 R11", "R10 R11", "R10 R11", "R10 R11");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1-watchdog run did not complete: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chip_en = 1'b0; fmt_reader = 1'b0; frame_start = 1'b0;
        byte_valid = 1'b0; byte_data = '0; byte_last = 1'b0;
        en_prev = 0; busy_prev = 0; rdy_prev = 0; last_out = 1; en_ctr = 0;
        cap_n = 0; feed_n = 0; feed_idx = 0; gate = 0; sof_end = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_tag_frame();
        test_reader_frame();
        test_tag_underrun();
        test_format_and_restart();
        finished = 1;
        summary();
        $finish;
    end

endmodule